// File: doc/BRIEF.md
# Core Stall Watchdog with Event Heartbeat

This block watches one processor core for forward progress. The core provides a set of single-cycle performance-event pulses, such as a load retiring, a store retiring or any instruction completing. A select field picks one of these pulses as the heartbeat. A free-running strobe that fires once every 10 ns splits time into intervals. A saturating stall counter advances at each strobe when no heartbeat arrived during the interval just ending. It returns to zero at any strobe that closes an interval in which a heartbeat was seen.

When the count reaches the programmed limit, a sticky hang interrupt goes high. The hang time is therefore the limit value multiplied by 10 ns. Software controls the block through a small valid/write register bus. One register holds the limit. A control register holds the enable, the heartbeat select, the interrupt status and a write-only clear bit. A chip places one instance per core, and each instance has its own registers.

Top module: `core_stall_watchdog`

## Requirements
- R1: After reset, `hang_irq` is 0, `bus_rdata` is 0, the limit register reads 0 and the control register reads 0 (monitor disabled).
- R2: With the monitor enabled and limit T (1 to 2^CNT_W-1), `hang_irq` rises one clock after the T-th consecutive strobe whose interval held no heartbeat. It is still 0 after T-1 such strobes.
- R3: A heartbeat pulse anywhere in an interval returns the count to zero at the strobe that closes the interval. This includes a pulse in the same cycle as that strobe.
- R4: Only the event input whose index equals control bits [3:1] acts as the heartbeat. Pulses on any other event input have no effect on the count.
- R5: While control bit 0 (enable) is 0, the count stays at zero and `hang_irq` stays 0. After enabling, a full T empty strobes are needed to fire.
- R6: A limit of 0 never raises `hang_irq`, however many strobes pass.
- R7: The stall count saturates at its all-ones value instead of wrapping. A limit equal to that value still fires, and the interrupt stays up as strobes continue.
- R8: `hang_irq` is sticky. It falls only when software writes the control register with enable 0 or with bit 5 (clear) set. When a clear write meets the set condition in the same cycle, the clear wins and the count restarts from zero.
- R9: Any write to the limit register, and any control write that changes the select or sets the clear bit, restarts the count at zero. A control write that leaves the select unchanged does not restart it.
- R10: A read (valid high, write low) returns data on `bus_rdata` one clock later. Address 0 is the limit, zero-extended. Address 1 is control: bit 0 enable, bits [3:1] select, bit 4 interrupt status, and bit 5 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_10ns | input | 1 | One-cycle strobe marking the end of each 10 ns interval |
| core_evt | input | NUM_EVT | Single-cycle performance-event pulses from the core |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | Register address: 0 limit, 1 control |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| hang_irq | output | 1 | Sticky hang interrupt |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a heartbeat pulse is driven in the very cycle of a strobe. The bench judges it correct when the interval still counts as alive, so a full limit of further empty strobes is needed before the interrupt. In the second, a control write with the clear bit is issued in the cycle right after the strobe that makes the count reach the limit. The clear must win, the interrupt must stay low, and firing must again take exactly the limit number of strobes.

// File: rtl/csm_pkg.sv
package csm_pkg;
  // register addresses on the one-bit bus address
  typedef enum logic [0:0] {
    REG_LIMIT = 1'b0,
    REG_CTRL  = 1'b1
  } csm_reg_e;
endpackage

// File: rtl/csm_regs.sv
module csm_regs
  import csm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              irq_i,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  limit_o,
  output logic              en_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              restart_o,
  output logic              clr_o
);
  localparam int EN_BIT  = 0;
  localparam int SEL_LSB = 1;
  localparam int IRQ_BIT = SEL_W + 1;
  localparam int CLR_BIT = SEL_W + 2;

  logic             wr_lim, wr_ctl, rd_req;
  logic [SEL_W-1:0] new_sel;
  logic [DATA_W-1:0] ctl_word;
  logic             unused_wdata;

  assign wr_lim  = bus_valid && bus_write && (bus_addr == REG_LIMIT);
  assign wr_ctl  = bus_valid && bus_write && (bus_addr == REG_CTRL);
  assign rd_req  = bus_valid && !bus_write;
  assign new_sel = bus_wdata[SEL_LSB +: SEL_W];
  assign unused_wdata = ^bus_wdata;

  assign clr_o     = wr_ctl && (!bus_wdata[EN_BIT] || bus_wdata[CLR_BIT]);
  assign restart_o = wr_lim || (wr_ctl && ((new_sel != sel_o) || bus_wdata[CLR_BIT]));

  always_comb begin
    ctl_word = '0;
    ctl_word[EN_BIT] = en_o;
    ctl_word[SEL_LSB +: SEL_W] = sel_o;
    ctl_word[IRQ_BIT] = irq_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_o   <= '0;
      en_o      <= 1'b0;
      sel_o     <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_lim) limit_o <= bus_wdata[CNT_W-1:0];
      if (wr_ctl) begin
        en_o  <= bus_wdata[EN_BIT];
        sel_o <= new_sel;
      end
      if (rd_req)
        bus_rdata <= (bus_addr == REG_LIMIT) ? DATA_W'(limit_o) : ctl_word;
    end
  end

  // R9
  limit_write_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lim |-> restart_o);
endmodule

// File: rtl/csm_evt_latch.sv
module csm_evt_latch #(
  parameter int NUM_EVT = 8,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               tick_i,
  input  logic               flush_i,
  output logic               seen_o
);
  localparam int PAD_N = 2 ** SEL_W;

  logic [PAD_N-1:0] evt_pad;
  logic             hit, seen_q;

  assign evt_pad = PAD_N'(evt_i);
  assign hit     = evt_pad[sel_i];
  // a pulse in the strobe cycle still belongs to the closing interval
  assign seen_o  = seen_q || hit;

  always_ff @(posedge clk) begin
    if (rst || flush_i || tick_i) seen_q <= 1'b0;
    else if (hit)                 seen_q <= 1'b1;
  end

  // R3
  beat_held_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !tick_i && !flush_i) |=> seen_o);
endmodule

// File: rtl/csm_stall_cnt.sv
module csm_stall_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             seen_i,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             irq_set;

  always_ff @(posedge clk) begin
    if (rst || !en_i || restart_i) cnt_q <= '0;
    else if (tick_i) begin
      if (seen_i)                cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign irq_set = en_i && !restart_i && (limit_i != '0) && (cnt_q >= limit_i);

  always_ff @(posedge clk) begin
    if (rst || clr_i) irq_o <= 1'b0;
    else if (irq_set) irq_o <= 1'b1;
  end

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !seen_i && en_i && !restart_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R3
  beat_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && seen_i) |=> cnt_q == '0);
  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> cnt_q == '0);
  // R6
  zero_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (limit_i == '0 && !irq_o) |=> !irq_o);
  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !seen_i && en_i && !restart_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !clr_i) |=> irq_o);
  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !irq_o);
endmodule

// File: rtl/core_stall_watchdog.sv
module core_stall_watchdog #(
  parameter int NUM_EVT = 8,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_10ns,
  input  logic [NUM_EVT-1:0] core_evt,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic               bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               hang_irq
);
  localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic [CNT_W-1:0] limit;
  logic             en, restart, clr, seen;
  logic [SEL_W-1:0] sel;

  csm_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_i(hang_irq),
    .bus_rdata(bus_rdata), .limit_o(limit), .en_o(en), .sel_o(sel),
    .restart_o(restart), .clr_o(clr)
  );

  csm_evt_latch #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_latch (
    .clk(clk), .rst(rst), .evt_i(core_evt), .sel_i(sel), .tick_i(tick_10ns),
    .flush_i(!en || restart), .seen_o(seen)
  );

  csm_stall_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick_10ns), .seen_i(seen), .en_i(en),
    .restart_i(restart), .clr_i(clr), .limit_i(limit), .irq_o(hang_irq)
  );

  // R5
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> !hang_irq);
endmodule

// File: tb/sim_core_stall_watchdog.sv
module sim_core_stall_watchdog;
  localparam int CLK_P = 10;
  localparam int NE = 8;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic [NE-1:0] evt = '0;
  logic bv = 1'b0, bw = 1'b0, ba = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic irq;
  int vectors = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  core_stall_watchdog #(.NUM_EVT(NE), .CNT_W(4), .DATA_W(32)) u0 (
    .clk(clk), .rst(rst), .tick_10ns(tick), .core_evt(evt), .bus_valid(bv),
    .bus_write(bw), .bus_addr(ba), .bus_wdata(wd), .bus_rdata(rd), .hang_irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); bv = 1; bw = 1; ba = a; wd = d;
    @(negedge clk); bv = 0; bw = 0; wd = '0;
  endtask

  task automatic rdr(input logic a, output logic [31:0] d);
    @(negedge clk); bv = 1; bw = 0; ba = a;
    @(negedge clk); bv = 0; d = rd;
  endtask

  task automatic tk(input logic [NE-1:0] m);
    @(negedge clk); tick = 1; evt = m;
    @(negedge clk); tick = 0; evt = '0;
    @(negedge clk);
  endtask

  task automatic pulse(input int i);
    @(negedge clk); evt[i] = 1'b1;
    @(negedge clk); evt = '0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tk('0);
  endtask

  function automatic logic [31:0] ctl(input int en, input int s);
    return 32'(en) | (32'(s) << 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rdata", rd, 0);
    rdr(1'b0, v); chk("R1 limit", v, 0);
    rdr(1'b1, v); chk("R1 ctrl", v, 0);

    // R2/R4/R10 sweep over every select and limits 1..5
    for (int s = 0; s < NE; s++) begin
      for (int t = 1; t <= 5; t++) begin
        wr(1'b1, 0);
        wr(1'b0, 32'(t));
        wr(1'b1, ctl(1, s));
        for (int k = 0; k < t - 1; k++) begin
          pulse((s + 1) % NE);   // R4 foreign event ignored
          tk('0);
        end
        chk("R2/R4 before limit", 32'(irq), 0);
        tk('0);
        chk("R2 at limit", 32'(irq), 1);
        rdr(1'b1, v); chk("R10 ctrl status", v, ctl(1, s) | 32'h10);
        rdr(1'b0, v); chk("R10 limit", v, 32'(t));
      end
    end

    // R3 heartbeat mid-interval and in the strobe cycle
    wr(1'b1, 0); wr(1'b0, 4); wr(1'b1, ctl(1, 5));
    ticks(3); pulse(5); tk('0);
    ticks(2); chk("R3 mid-interval beat", 32'(irq), 0);
    tk('0); chk("R3 fires after full run", 32'(irq), 0);
    tk('0); chk("R3 fires after full run", 32'(irq), 1);
    wr(1'b1, 0); wr(1'b1, ctl(1, 5));
    ticks(3); tk(8'h20);
    ticks(3); chk("R3 beat on strobe", 32'(irq), 0);
    tk('0); chk("R3 beat on strobe then limit", 32'(irq), 1);

    // R8 clear by enable 0
    wr(1'b1, 0); chk("R8 disable clears", 32'(irq), 0);
    rdr(1'b1, v); chk("R8 status after disable", v, 0);

    // R5 disabled: no counting
    wr(1'b0, 2); ticks(10); chk("R5 disabled", 32'(irq), 0);
    wr(1'b1, ctl(1, 0));
    tk('0); chk("R5 fresh after enable", 32'(irq), 0);
    tk('0); chk("R5 fires after enable", 32'(irq), 1);

    // R8 clear bit keeps enable, reads back as 0
    wr(1'b1, ctl(1, 0) | 32'h20);
    chk("R8 clear bit", 32'(irq), 0);
    rdr(1'b1, v); chk("R10 clear reads 0", v, ctl(1, 0));
    ticks(3); chk("R8 sticky after refire", 32'(irq), 1);

    // R6 limit 0
    wr(1'b1, 0); wr(1'b0, 0); wr(1'b1, ctl(1, 2));
    ticks(40); chk("R6 zero limit", 32'(irq), 0);

    // R7 saturation at 15
    wr(1'b0, 15);
    ticks(14); chk("R7 before max", 32'(irq), 0);
    tk('0); chk("R7 max limit fires", 32'(irq), 1);
    ticks(30); chk("R7 held past saturation", 32'(irq), 1);

    // R9 limit rewrite restarts
    wr(1'b1, 0); wr(1'b0, 3); wr(1'b1, ctl(1, 2));
    ticks(2); wr(1'b0, 3);
    ticks(2); chk("R9 limit rewrite", 32'(irq), 0);
    tk('0); chk("R9 limit rewrite fire", 32'(irq), 1);
    // R9 select change restarts
    wr(1'b1, 0); wr(1'b1, ctl(1, 2));
    ticks(2); wr(1'b1, ctl(1, 6));
    ticks(2); chk("R9 select change", 32'(irq), 0);
    tk('0); chk("R9 select change fire", 32'(irq), 1);
    // R9 same select keeps count
    wr(1'b1, 0); wr(1'b1, ctl(1, 6));
    ticks(2); wr(1'b1, ctl(1, 6));
    tk('0); chk("R9 same select no restart", 32'(irq), 1);

    // R8 clear write in the cycle the set condition appears
    wr(1'b1, 0); wr(1'b1, ctl(1, 2));
    ticks(2);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0; bv = 1; bw = 1; ba = 1'b1; wd = ctl(1, 2) | 32'h20;
    @(negedge clk); bv = 0; bw = 0; wd = '0;
    chk("R8 clear wins", 32'(irq), 0);
    ticks(2); chk("R8 restart after clear", 32'(irq), 0);
    tk('0); chk("R8 refire after clear", 32'(irq), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule